// File: doc/BRIEF.md
# In-Band Xon/Xoff and RTS Flow Controller

This per-channel block automates software and hardware flow control around a 16-entry receive FIFO. It watches the stream of received characters for the programmed Xon and Xoff codes. It decides for each received character whether the character goes into the receive FIFO or is dropped. Depending on the flow mode, it either gates the local transmitter or asks the transmit path to insert Xon or Xoff as the receive FIFO fills and drains. It also drives an active-low request-to-send output and raises a flag when a flow character arrives.

The flow mode has two bits. Bit 0 enables automatic transmitter gating: a received Xoff stops the transmitter and a received Xon restarts it. Bit 1 enables automatic receiver throttling: Xoff is requested when the FIFO holds 12 characters, and Xon is requested once it holds 8 or fewer. Mode 00 is host mode, in which only the two host command strobes can request Xon or Xoff. Pending insertion requests are served when the serializer reports a character boundary, and they win over ordinary TX FIFO data.

There are four state machines:
- Transmit gate: `TXG_RUN` and `TXG_HALT`. Run goes to halt on a received Xoff while bit 0 is set. Halt goes back to run on a received Xon, or when bit 0 is cleared.
- Receive throttle: `RXT_OPEN` and `RXT_THROTTLED`. Open goes to throttled when the fill level reaches the high mark under bit 1, and this requests Xoff. Throttled goes to open when the level falls to the low mark, which requests Xon, or silently when bit 1 is cleared.
- Request-to-send: `RTS_ON` and `RTS_OFF`. On goes to off on a start bit at 3/4 full with auto control enabled. Off goes to on when the level drops below 3/4, or when auto control is disabled.
- Insertion: `INS_IDLE`, `INS_PEND_XON` and `INS_PEND_XOFF`. A new request moves to the matching pending state and overrides any older one. A grant at a character boundary returns to idle.

A fifth machine, `IRQ_IDLE` and `IRQ_RAISED`, holds the interrupt flag.

Top module: `inband_flow_ctrl`

## Requirements
- R1: Host command strobes queue an Xon or Xoff insertion only when `flow_mode` is 00; in any other mode they have no effect. When both strobes arrive in the same cycle, Xoff is queued.
- R2: When `flow_mode[0]` is 1, a received Xoff drops `tx_gate` from the following cycle, and a received Xon raises it again. While `flow_mode[0]` is 0, `tx_gate` is 1.
- R3: When `flow_mode[1]` is 1 and `rx_level` reaches 12 or more, a single Xoff insertion is queued. It is granted at the next character boundary.
- R4: After that Xoff, a single Xon insertion is queued once `rx_level` is 8 or less. Refills to 12 while the level stays above 8 queue nothing more.
- R5: `rx_push` is 1 for an ordinary received character. For a character equal to the Xon or Xoff code, `rx_push` equals `transparent`.
- R6: A received flow character with `irq_en` set makes `flow_irq` 1 from the next cycle. `stat_rd` clears the flag. A flow character arriving in the same cycle as `stat_rd` wins. Flow characters with `irq_en` clear leave the flag unchanged.
- R7: With `rts_auto` set, `rts_n` goes to 1 in the cycle after an `rx_start` pulse that sees `rx_level` at 12 or more. The level alone, without a start bit, does nothing. With `rts_auto` clear, `rts_n` stays 0.
- R8: Once negated, `rts_n` returns to 0 in the cycle after `rx_level` falls below 12.
- R9: At a `char_boundary` cycle at most one of the grants fires, in this order of priority: `ins_xoff_grant`, then `ins_xon_grant`, then `tx_pop`. `tx_pop` requires `txq_valid` and `tx_gate`.
- R10: After reset, `tx_gate` is 1, `rts_n` is 0, `flow_irq` is 0, and no insertion is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A received character is presented this cycle |
| rx_char | input | 8 | Received character |
| rx_start | input | 1 | Valid start bit detected |
| rx_level | input | 5 | Receive FIFO fill level, 0 to 16 |
| xon_code | input | 8 | Xon character code |
| xoff_code | input | 8 | Xoff character code |
| flow_mode | input | 2 | Bit 0 enables auto transmitter gating; bit 1 enables auto receiver throttling |
| transparent | input | 1 | 1: flow characters are pushed into the FIFO; 0: they are stripped |
| rts_auto | input | 1 | Enables automatic RTS negation |
| irq_en | input | 1 | Interrupt mask bit for flow characters |
| stat_rd | input | 1 | Status read strobe; clears the flag |
| host_xon_cmd | input | 1 | Host request to send Xon |
| host_xoff_cmd | input | 1 | Host request to send Xoff |
| char_boundary | input | 1 | The serializer can accept its next character |
| txq_valid | input | 1 | The TX FIFO holds data |
| rx_push | output | 1 | Push the current received character into the FIFO |
| tx_gate | output | 1 | The transmitter may send FIFO data |
| ins_xon_grant | output | 1 | Send the Xon code at this boundary |
| ins_xoff_grant | output | 1 | Send the Xoff code at this boundary |
| tx_pop | output | 1 | Send TX FIFO data at this boundary |
| rts_n | output | 1 | Request to send, active low |
| flow_irq | output | 1 | A flow character was received |

## Verification
The properties assume the following about the inputs:
- `rx_valid` is a one-cycle qualifier for `rx_char`.
- `rx_level` never exceeds the FIFO depth.
- `char_boundary` is a single-cycle strobe.
- When the Xon and Xoff codes are equal, the character counts as Xoff.

The stimulus drives every strobe for exactly one cycle and keeps the two codes distinct. It moves `rx_level` in steps that cross each mark from both sides, so the throttle hysteresis band and the RTS mark are each entered and left. Mode changes are made only between strobes, so that each property sees a settled mode.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic {
        TXG_RUN,
        TXG_HALT
    } txg_state_e;

    typedef enum logic {
        RXT_OPEN,
        RXT_THROTTLED
    } rxt_state_e;

    typedef enum logic {
        RTS_ON,
        RTS_OFF
    } rts_state_e;

    typedef enum logic [1:0] {
        INS_IDLE,
        INS_PEND_XON,
        INS_PEND_XOFF
    } ins_state_e;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_RAISED
    } irq_state_e;

    localparam int MODE_AUTO_TX_BIT = 0;
    localparam int MODE_AUTO_RX_BIT = 1;

endpackage

// File: rtl/fc_char_match.sv
module fc_char_match
    import fc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_char,
    input  logic [DATA_W-1:0] xon_code,
    input  logic [DATA_W-1:0] xoff_code,
    input  logic              transparent,
    input  logic              irq_en,
    input  logic              stat_rd,
    output logic              hit_xon,
    output logic              hit_xoff,
    output logic              rx_push,
    output logic              flow_irq
);

    irq_state_e irq_q, irq_d;
    logic       is_flow;

    // Xoff wins when both codes are programmed to the same value
    always_comb begin
        hit_xoff = rx_valid && (rx_char == xoff_code);
        hit_xon  = rx_valid && (rx_char == xon_code) && (rx_char != xoff_code);
        is_flow  = hit_xon || hit_xoff;
        rx_push  = rx_valid && (transparent || !is_flow);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= IRQ_IDLE;
        else        irq_q <= irq_d;
    end

    always_comb begin
        irq_d = irq_q;
        unique case (irq_q)
            IRQ_IDLE:   if (is_flow && irq_en) irq_d = IRQ_RAISED;
            IRQ_RAISED: if (!(is_flow && irq_en) && stat_rd) irq_d = IRQ_IDLE;
            default:    irq_d = IRQ_IDLE;
        endcase
    end

    assign flow_irq = (irq_q == IRQ_RAISED);

endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate
    import fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_tx,
    input  logic hit_xon,
    input  logic hit_xoff,
    output logic tx_gate
);

    txg_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TXG_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TXG_RUN:  if (auto_tx && hit_xoff) st_d = TXG_HALT;
            TXG_HALT: if (!auto_tx || hit_xon) st_d = TXG_RUN;
            default:  st_d = TXG_RUN;
        endcase
    end

    assign tx_gate = (st_q == TXG_RUN) || !auto_tx;

endmodule

// File: rtl/fc_rx_watch.sv
module fc_rx_watch
    import fc_pkg::*;
#(
    parameter int LVL_W    = 5,
    parameter int HI_MARK  = 12,
    parameter int LO_MARK  = 8,
    parameter int RTS_MARK = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_rx,
    input  logic             rts_auto,
    input  logic             rx_start,
    input  logic [LVL_W-1:0] rx_level,
    output logic             req_xon,
    output logic             req_xoff,
    output logic             rts_n
);

    rxt_state_e thr_q, thr_d;
    rts_state_e rts_q, rts_d;
    int         lvl;

    assign lvl = int'(rx_level);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= RXT_OPEN;
            rts_q <= RTS_ON;
        end else begin
            thr_q <= thr_d;
            rts_q <= rts_d;
        end
    end

    // Throttle machine: Mealy request pulses on the transitions
    always_comb begin
        thr_d    = thr_q;
        req_xon  = 1'b0;
        req_xoff = 1'b0;
        unique case (thr_q)
            RXT_OPEN: begin
                if (auto_rx && lvl >= HI_MARK) begin
                    thr_d    = RXT_THROTTLED;
                    req_xoff = 1'b1;
                end
            end
            RXT_THROTTLED: begin
                if (!auto_rx) begin
                    thr_d = RXT_OPEN;
                end else if (lvl <= LO_MARK) begin
                    thr_d   = RXT_OPEN;
                    req_xon = 1'b1;
                end
            end
            default: thr_d = RXT_OPEN;
        endcase
    end

    always_comb begin
        rts_d = rts_q;
        unique case (rts_q)
            RTS_ON:  if (rts_auto && rx_start && lvl >= RTS_MARK) rts_d = RTS_OFF;
            RTS_OFF: if (!rts_auto || lvl < RTS_MARK) rts_d = RTS_ON;
            default: rts_d = RTS_ON;
        endcase
    end

    assign rts_n = (rts_q == RTS_OFF);

endmodule

// File: rtl/fc_tx_insert.sv
module fc_tx_insert
    import fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_xon,
    input  logic req_xoff,
    input  logic char_boundary,
    input  logic txq_valid,
    input  logic tx_gate,
    output logic ins_xon_grant,
    output logic ins_xoff_grant,
    output logic tx_pop
);

    ins_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= INS_IDLE;
        else        st_q <= st_d;
    end

    // A granted request returns to idle; a fresh request overrides it
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            INS_IDLE:      st_d = INS_IDLE;
            INS_PEND_XON:  if (char_boundary) st_d = INS_IDLE;
            INS_PEND_XOFF: if (char_boundary) st_d = INS_IDLE;
            default:       st_d = INS_IDLE;
        endcase
        if (req_xoff)     st_d = INS_PEND_XOFF;
        else if (req_xon) st_d = INS_PEND_XON;
    end

    always_comb begin
        ins_xon_grant  = 1'b0;
        ins_xoff_grant = 1'b0;
        tx_pop         = 1'b0;
        unique case (st_q)
            INS_PEND_XOFF: ins_xoff_grant = char_boundary;
            INS_PEND_XON:  ins_xon_grant  = char_boundary;
            INS_IDLE:      tx_pop = char_boundary && txq_valid && tx_gate;
            default:       tx_pop = 1'b0;
        endcase
    end

endmodule

// File: rtl/inband_flow_ctrl.sv
module inband_flow_ctrl
    import fc_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
    localparam int XOFF_MARK = (FIFO_DEPTH * 3) / 4,
    localparam int XON_MARK  = FIFO_DEPTH / 2,
    localparam int RTS_MARK  = (FIFO_DEPTH * 3) / 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_char,
    input  logic              rx_start,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [DATA_W-1:0] xon_code,
    input  logic [DATA_W-1:0] xoff_code,
    input  logic [1:0]        flow_mode,
    input  logic              transparent,
    input  logic              rts_auto,
    input  logic              irq_en,
    input  logic              stat_rd,
    input  logic              host_xon_cmd,
    input  logic              host_xoff_cmd,
    input  logic              char_boundary,
    input  logic              txq_valid,
    output logic              rx_push,
    output logic              tx_gate,
    output logic              ins_xon_grant,
    output logic              ins_xoff_grant,
    output logic              tx_pop,
    output logic              rts_n,
    output logic              flow_irq
);

    logic hit_xon, hit_xoff;
    logic thr_xon, thr_xoff;
    logic req_xon, req_xoff;
    logic host_mode;

    assign host_mode = (flow_mode == 2'b00);
    assign req_xon   = host_mode ? host_xon_cmd  : thr_xon;
    assign req_xoff  = host_mode ? host_xoff_cmd : thr_xoff;

    fc_char_match #(.DATA_W(DATA_W)) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_char     (rx_char),
        .xon_code    (xon_code),
        .xoff_code   (xoff_code),
        .transparent (transparent),
        .irq_en      (irq_en),
        .stat_rd     (stat_rd),
        .hit_xon     (hit_xon),
        .hit_xoff    (hit_xoff),
        .rx_push     (rx_push),
        .flow_irq    (flow_irq)
    );

    fc_tx_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_tx  (flow_mode[MODE_AUTO_TX_BIT]),
        .hit_xon  (hit_xon),
        .hit_xoff (hit_xoff),
        .tx_gate  (tx_gate)
    );

    fc_rx_watch #(
        .LVL_W    (LVL_W),
        .HI_MARK  (XOFF_MARK),
        .LO_MARK  (XON_MARK),
        .RTS_MARK (RTS_MARK)
    ) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_rx  (flow_mode[MODE_AUTO_RX_BIT]),
        .rts_auto (rts_auto),
        .rx_start (rx_start),
        .rx_level (rx_level),
        .req_xon  (thr_xon),
        .req_xoff (thr_xoff),
        .rts_n    (rts_n)
    );

    fc_tx_insert u_ins (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_xon        (req_xon),
        .req_xoff       (req_xoff),
        .char_boundary  (char_boundary),
        .txq_valid      (txq_valid),
        .tx_gate        (tx_gate),
        .ins_xon_grant  (ins_xon_grant),
        .ins_xoff_grant (ins_xoff_grant),
        .tx_pop         (tx_pop)
    );

endmodule

// File: rtl/fc_flow_chk.sv
module fc_flow_chk #(
    parameter int DATA_W   = 8,
    parameter int LVL_W    = 5,
    parameter int RTS_MARK = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_char,
    input logic              rx_start,
    input logic [LVL_W-1:0]  rx_level,
    input logic [DATA_W-1:0] xon_code,
    input logic [DATA_W-1:0] xoff_code,
    input logic [1:0]        flow_mode,
    input logic              transparent,
    input logic              rts_auto,
    input logic              irq_en,
    input logic              stat_rd,
    input logic              char_boundary,
    input logic              txq_valid,
    input logic              rx_push,
    input logic              tx_gate,
    input logic              ins_xon_grant,
    input logic              ins_xoff_grant,
    input logic              tx_pop,
    input logic              rts_n,
    input logic              flow_irq
);

    logic flow_char;
    assign flow_char = rx_valid && ((rx_char == xon_code) || (rx_char == xoff_code));

    // R2
    halt_on_xoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_char == xoff_code && flow_mode[0]) |=> (!tx_gate || !flow_mode[0]));

    // R5
    strip_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_char && !transparent) |-> !rx_push);

    // R6
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_char && irq_en) |=> flow_irq);

    // R6
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !(flow_char && irq_en)) |=> !flow_irq);

    // R7
    rts_negate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_auto && rx_start && int'(rx_level) >= RTS_MARK) |=> (rts_n || !rts_auto));

    // R7
    rts_only_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts_n) |-> $past(rx_start && rts_auto));

    // R8
    rts_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_n && int'(rx_level) < RTS_MARK) |=> !rts_n);

    // R9
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ins_xon_grant, ins_xoff_grant, tx_pop}));

    // R9
    pop_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (tx_gate && char_boundary && txq_valid));

endmodule

bind inband_flow_ctrl fc_flow_chk #(
    .DATA_W   (DATA_W),
    .LVL_W    (LVL_W),
    .RTS_MARK (RTS_MARK)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_valid       (rx_valid),
    .rx_char        (rx_char),
    .rx_start       (rx_start),
    .rx_level       (rx_level),
    .xon_code       (xon_code),
    .xoff_code      (xoff_code),
    .flow_mode      (flow_mode),
    .transparent    (transparent),
    .rts_auto       (rts_auto),
    .irq_en         (irq_en),
    .stat_rd        (stat_rd),
    .char_boundary  (char_boundary),
    .txq_valid      (txq_valid),
    .rx_push        (rx_push),
    .tx_gate        (tx_gate),
    .ins_xon_grant  (ins_xon_grant),
    .ins_xoff_grant (ins_xoff_grant),
    .tx_pop         (tx_pop),
    .rts_n          (rts_n),
    .flow_irq       (flow_irq)
);

// File: tb/inband_flow_ctrl_tb.sv
module inband_flow_ctrl_tb;

    localparam logic [7:0] XON  = 8'h11;
    localparam logic [7:0] XOFF = 8'h13;
    // scoreboard item codes: 0 nothing, 1 xon, 2 xoff, 3 data pop
    localparam int E_NONE = 0, E_XON = 1, E_XOFF = 2, E_POP = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0, rx_start = 1'b0;
    logic [7:0] rx_char = 8'h00;
    logic [4:0] rx_level = 5'd0;
    logic [1:0] flow_mode = 2'b00;
    logic       transparent = 1'b0, rts_auto = 1'b0, irq_en = 1'b1, stat_rd = 1'b0;
    logic       host_xon_cmd = 1'b0, host_xoff_cmd = 1'b0;
    logic       char_boundary = 1'b0, txq_valid = 1'b0;
    logic       rx_push, tx_gate, ins_xon_grant, ins_xoff_grant, tx_pop, rts_n, flow_irq;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    inband_flow_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
        .rx_start(rx_start), .rx_level(rx_level), .xon_code(XON), .xoff_code(XOFF),
        .flow_mode(flow_mode), .transparent(transparent), .rts_auto(rts_auto),
        .irq_en(irq_en), .stat_rd(stat_rd), .host_xon_cmd(host_xon_cmd),
        .host_xoff_cmd(host_xoff_cmd), .char_boundary(char_boundary),
        .txq_valid(txq_valid), .rx_push(rx_push), .tx_gate(tx_gate),
        .ins_xon_grant(ins_xon_grant), .ins_xoff_grant(ins_xoff_grant),
        .tx_pop(tx_pop), .rts_n(rts_n), .flow_irq(flow_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // driver: one boundary cycle, expected grant queued for the monitor
    task automatic boundary(input string req, input int exp);
        char_boundary = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        tick();
        char_boundary = 1'b0;
    endtask

    // monitor: compares the grant seen at each boundary with the queue
    always @(negedge clk) begin
        if (rst_n && char_boundary) begin
            int act;
            act = ins_xoff_grant ? E_XOFF : ins_xon_grant ? E_XON : tx_pop ? E_POP : E_NONE;
            if (exp_q.size() == 0) begin
                check("unexpected boundary", act, -1);
            end else begin
                string t;
                int e;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, act, e);
            end
        end
    end

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R10 reset state
        tick(); tick();
        @(negedge clk);
        check("R10 tx_gate", int'(tx_gate), 1);
        check("R10 rts_n", int'(rts_n), 0);
        check("R10 flow_irq", int'(flow_irq), 0);
        rst_n = 1'b1;
        tick();
        boundary("R10 nothing pending", E_NONE);

        // R5 strip, R6 raise
        rx_valid = 1'b1; rx_char = XOFF;
        @(negedge clk); check("R5 stripped xoff", int'(rx_push), 0);
        tick(); rx_valid = 1'b0;
        @(negedge clk);
        check("R6 irq raised", int'(flow_irq), 1);
        check("R2 gate open in host mode", int'(tx_gate), 1);
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        @(negedge clk); check("R6 irq cleared", int'(flow_irq), 0);
        boundary("R1 received xoff queues nothing in host mode", E_NONE);

        transparent = 1'b1; rx_valid = 1'b1; rx_char = XON;
        @(negedge clk); check("R5 transparent push", int'(rx_push), 1);
        tick(); rx_valid = 1'b0; transparent = 1'b0;
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        irq_en = 1'b0; rx_valid = 1'b1; rx_char = XOFF;
        tick(); rx_valid = 1'b0; irq_en = 1'b1;
        @(negedge clk); check("R6 masked no irq", int'(flow_irq), 0);
        rx_valid = 1'b1; rx_char = 8'h41;
        @(negedge clk); check("R5 ordinary push", int'(rx_push), 1);
        tick(); rx_valid = 1'b0;
        @(negedge clk); check("R6 ordinary no irq", int'(flow_irq), 0);
        rx_valid = 1'b1; rx_char = XON; stat_rd = 1'b1;
        tick(); rx_valid = 1'b0; stat_rd = 1'b0;
        @(negedge clk); check("R6 set wins over read", int'(flow_irq), 1);
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;

        // R1 host commands
        host_xoff_cmd = 1'b1; tick(); host_xoff_cmd = 1'b0;
        boundary("R1 host xoff", E_XOFF);
        host_xon_cmd = 1'b1; tick(); host_xon_cmd = 1'b0;
        boundary("R1 host xon", E_XON);
        host_xon_cmd = 1'b1; host_xoff_cmd = 1'b1; tick();
        host_xon_cmd = 1'b0; host_xoff_cmd = 1'b0;
        boundary("R1 both strobes xoff", E_XOFF);
        boundary("R1 single grant", E_NONE);
        flow_mode = 2'b01;
        host_xoff_cmd = 1'b1; tick(); host_xoff_cmd = 1'b0;
        boundary("R1 blocked in mode 01", E_NONE);
        flow_mode = 2'b10;
        host_xon_cmd = 1'b1; tick(); host_xon_cmd = 1'b0;
        boundary("R1 blocked in mode 10", E_NONE);

        // R9 priority over data
        flow_mode = 2'b00; txq_valid = 1'b1;
        host_xon_cmd = 1'b1; tick(); host_xon_cmd = 1'b0;
        boundary("R9 xon before data", E_XON);
        boundary("R9 data after insertion", E_POP);
        txq_valid = 1'b0;

        // R2 auto transmitter gating
        flow_mode = 2'b01;
        rx_valid = 1'b1; rx_char = XOFF; tick(); rx_valid = 1'b0;
        @(negedge clk); check("R2 halted by xoff", int'(tx_gate), 0);
        txq_valid = 1'b1;
        boundary("R9 no pop while halted", E_NONE);
        rx_valid = 1'b1; rx_char = XON; tick(); rx_valid = 1'b0;
        @(negedge clk); check("R2 resumed by xon", int'(tx_gate), 1);
        boundary("R9 pop after resume", E_POP);
        txq_valid = 1'b0;
        rx_valid = 1'b1; rx_char = XOFF; tick(); rx_valid = 1'b0;
        @(negedge clk); check("R2 halted again", int'(tx_gate), 0);
        flow_mode = 2'b00; #1;
        check("R2 gate open when auto tx off", int'(tx_gate), 1);
        tick(); flow_mode = 2'b01;
        @(negedge clk); check("R2 gate stays open after mode return", int'(tx_gate), 1);
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;

        // R3 / R4 receiver throttle with hysteresis
        flow_mode = 2'b10;
        rx_level = 5'd11; tick();
        boundary("R3 below mark", E_NONE);
        rx_level = 5'd12; tick();
        boundary("R3 xoff at 12", E_XOFF);
        rx_level = 5'd10; tick();
        rx_level = 5'd12; tick();
        boundary("R4 no resend in band", E_NONE);
        rx_level = 5'd9; tick();
        boundary("R4 no xon at 9", E_NONE);
        rx_level = 5'd8; tick();
        boundary("R4 xon at 8", E_XON);
        rx_level = 5'd12; tick();
        boundary("R3 xoff on new crossing", E_XOFF);
        rx_level = 5'd0; tick();
        boundary("R4 xon after drain", E_XON);

        // R7 / R8 request to send
        flow_mode = 2'b00; rts_auto = 1'b1;
        rx_level = 5'd12; tick();
        @(negedge clk); check("R7 no negate without start", int'(rts_n), 0);
        rx_start = 1'b1; tick(); rx_start = 1'b0;
        @(negedge clk); check("R7 negated on start at 3/4", int'(rts_n), 1);
        tick();
        @(negedge clk); check("R7 held while at 3/4", int'(rts_n), 1);
        rx_level = 5'd11; tick();
        @(negedge clk); check("R8 reasserted below 3/4", int'(rts_n), 0);
        rx_start = 1'b1; tick(); rx_start = 1'b0;
        @(negedge clk); check("R7 start below mark", int'(rts_n), 0);
        rts_auto = 1'b0; rx_level = 5'd15;
        rx_start = 1'b1; tick(); rx_start = 1'b0;
        @(negedge clk); check("R7 disabled auto", int'(rts_n), 0);

        tick(); tick();
        check("scoreboard drained", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule